// File: doc/BRIEF.md
# DRAM Bank-Interleave Command Pattern Generator

This block drives a fixed, endlessly repeating DRAM command stream, one command per clock. It is meant for supply-current characterisation and stress traffic. In each loop it opens a row in every bank, in ascending bank order. Each open row is followed at once by a burst-of-four read that closes the bank again through auto-precharge. The stream therefore contains activates, reads with auto-precharge and deselects, and never an explicit precharge. Three speed grades are supported. Each grade pads the stream with its own number of deselects so that bank-to-bank activate spacing, the four-activate window and the same-bank row cycle are all met at that grade's clock period.

The enable and the grade select are taken only at loop boundaries, so a loop always runs to completion with one grade. A built-in checker turns the nanosecond limits into cycle counts for the latched grade. It tracks the age of past activates and raises a sticky flag if any spacing rule is broken. Row and column addresses are deterministic: the row equals the bank number and the column is zero.

Top module: `dram_ilv_gen`

## Requirements
- R1: While rst_ni is low and after its release until the first command, cmd_o is deselect (2'b00), cmd_vld_o is 0, bank_o is 0, addr_o is 0 and viol_o is 0.
- R2: cmd_o encodes deselect as 2'b00, activate as 2'b01 and read with auto-precharge as 2'b10; cmd_vld_o is 1 exactly when cmd_o is not a deselect.
- R3: With grade 0 latched, every bank gets activate then read, with no deselect between banks, and two deselects follow the read of bank 3 and the read of bank 7 (20 slots per loop).
- R4: With grade 1 latched, every bank gets activate, read, deselect, and bank 3 and bank 7 each get one further deselect (26 slots per loop).
- R5: With grade 2 or 3 latched, every bank gets activate, read, deselect, and bank 3 and bank 7 each get two further deselects (28 slots per loop).
- R6: Banks are visited 0 to 7 in ascending order, and the next loop's bank 0 activate follows the last slot of bank 7 with no extra gap.
- R7: An activate drives addr_o equal to its bank number; a read drives the same bank as the preceding activate and addr_o equal to 0.
- R8: During every deselect slot, bank_o and addr_o keep the values of the previous cycle.
- R9: en_i and grade_i are sampled only at a loop boundary, meaning while idle or at the edge after the last slot of bank 7. If en_i is 1 there, the bank 0 activate appears on the outputs after that edge with the sampled grade latched. If en_i is 0 there, the block goes idle and issues deselects.
- R10: viol_o is sticky until reset. It is set when an activate comes earlier than ceil(7.5 ns/tCK) cycles after any activate, earlier than ceil(tFAW/tCK) cycles after the fourth-previous activate, or earlier than ceil(60 ns/tCK) cycles after the previous activate to its bank. tCK is 3.75, 3 or 2.5 ns and tFAW is 37.5, 37.5 or 35 ns for grade 0, 1 and 2/3. History restarts when the latched grade changes. No pattern or boundary grade change ever sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request, sampled at loop boundaries |
| grade_i | input | 2 | Speed-grade select, sampled at loop boundaries |
| cmd_o | output | 2 | Command code |
| bank_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Row address on activate, column on read |
| cmd_vld_o | output | 1 | High when a non-deselect command is driven |
| viol_o | output | 1 | Sticky spacing-violation flag |

## Verification
The hardest situation to reach from the ports is a grade change or an enable drop that lands exactly on the edge after bank 7's last deselect. A change one cycle earlier or later must be ignored or deferred by a whole loop. The stimulus first runs long directed stretches at each grade. It then toggles en_i and grade_i at random on most cycles, so many changes fall on boundaries and many fall mid-loop. A cycle-accurate bench model of slot position decides which of them may take effect. The violation flag is watched on every cycle, including the loops that follow a grade switch.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    CMD_DES = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RDA = 2'b10
  } cmd_e;

  localparam logic [1:0] GR_SLOW = 2'd0;
  localparam logic [1:0] GR_MID  = 2'd1;

  // deselects after every bank's read
  function automatic int unsigned pad_base(input logic [1:0] g);
    return (g == GR_SLOW) ? 0 : 1;
  endfunction

  // extra deselects at the end of each group of banks
  function automatic int unsigned pad_extra(input logic [1:0] g);
    return (g == GR_MID) ? 1 : 2;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int GROUP  = 4,
  parameter int PH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        grade_i,
  output cmd_e              iss_cmd_o,
  output logic [BANK_W-1:0] iss_bank_o,
  output logic [1:0]        gr_o
);

  localparam int GRP_W = $clog2(GROUP);
  localparam logic [BANK_W-1:0] LAST_BANK = '1;

  logic              run_q, run_d;
  logic [1:0]        gr_q, gr_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [PH_W-1:0]   last_ph;
  logic              grp_end, boundary;

  always_comb begin
    grp_end  = (bank_q[GRP_W-1:0] == '1);
    last_ph  = PH_W'(1 + pad_base(gr_q) + (grp_end ? pad_extra(gr_q) : 0));
    boundary = !run_q || ((ph_q == last_ph) && (bank_q == LAST_BANK));

    run_d      = run_q;
    gr_d       = gr_q;
    bank_d     = bank_q;
    ph_d       = ph_q;
    iss_cmd_o  = CMD_DES;
    iss_bank_o = bank_q;

    if (boundary) begin
      if (en_i) begin
        run_d      = 1'b1;
        gr_d       = grade_i;
        bank_d     = '0;
        ph_d       = '0;
        iss_cmd_o  = CMD_ACT;
        iss_bank_o = '0;
      end else begin
        run_d = 1'b0;
      end
    end else if (ph_q == last_ph) begin
      bank_d     = bank_q + BANK_W'(1);
      ph_d       = '0;
      iss_cmd_o  = CMD_ACT;
      iss_bank_o = bank_q + BANK_W'(1);
    end else begin
      ph_d = ph_q + PH_W'(1);
      if (ph_q == '0) iss_cmd_o = CMD_RDA;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      gr_q   <= GR_SLOW;
      bank_q <= '0;
      ph_q   <= '0;
    end else begin
      run_q  <= run_d;
      gr_q   <= gr_d;
      bank_q <= bank_d;
      ph_q   <= ph_d;
    end
  end

  assign gr_o = gr_q;

  AST_GRADE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !boundary) |=> $stable(gr_q)); // R9

  AST_PH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (ph_q <= last_ph)); // R6

  AST_BANK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !boundary && ph_q == last_ph) |=> (bank_q == $past(bank_q) + BANK_W'(1))); // R6

endmodule

// File: rtl/ilv_cmd_reg.sv
module ilv_cmd_reg
  import ilv_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              iss_cmd_i,
  input  logic [BANK_W-1:0] iss_bank_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o
);

  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_DES;
      bank_q <= '0;
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cmd_q <= iss_cmd_i;
      vld_q <= (iss_cmd_i != CMD_DES);
      unique case (iss_cmd_i)
        CMD_ACT: begin
          bank_q <= iss_bank_i;
          addr_q <= ADDR_W'(iss_bank_i);
        end
        CMD_RDA: begin
          bank_q <= iss_bank_i;
          addr_q <= '0;
        end
        default: ; // deselect: bus held
      endcase
    end
  end

  assign cmd_o  = cmd_q;
  assign bank_o = bank_q;
  assign addr_o = addr_q;
  assign vld_o  = vld_q;

  AST_DES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_DES) |-> ($stable(bank_q) && $stable(addr_q))); // R8

  AST_RDA_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RDA) |-> ($past(cmd_q) == CMD_ACT && $past(bank_q) == bank_q && addr_q == '0)); // R7

  AST_ROW_IS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_ACT) |-> (addr_q == ADDR_W'(bank_q))); // R7

  AST_VLD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q == (cmd_q != CMD_DES)); // R2

endmodule

// File: rtl/ilv_timing_chk.sv
module ilv_timing_chk
  import ilv_pkg::*;
#(
  parameter int BANK_W       = 3,
  parameter int AGE_W        = 6,
  parameter int TCK_SLOW_PS  = 3750,
  parameter int TCK_MID_PS   = 3000,
  parameter int TCK_FAST_PS  = 2500,
  parameter int T_RRD_PS     = 7500,
  parameter int T_RC_PS      = 60000,
  parameter int T_FAW_STD_PS = 37500,
  parameter int T_FAW_FST_PS = 35000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [1:0]        gr_i,
  output logic              viol_o
);

  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int WIN       = 4;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  localparam int RRD_S = ceil_div(T_RRD_PS, TCK_SLOW_PS);
  localparam int RRD_M = ceil_div(T_RRD_PS, TCK_MID_PS);
  localparam int RRD_F = ceil_div(T_RRD_PS, TCK_FAST_PS);
  localparam int FAW_S = ceil_div(T_FAW_STD_PS, TCK_SLOW_PS);
  localparam int FAW_M = ceil_div(T_FAW_STD_PS, TCK_MID_PS);
  localparam int FAW_F = ceil_div(T_FAW_FST_PS, TCK_FAST_PS);
  localparam int RC_S  = ceil_div(T_RC_PS, TCK_SLOW_PS);
  localparam int RC_M  = ceil_div(T_RC_PS, TCK_MID_PS);
  localparam int RC_F  = ceil_div(T_RC_PS, TCK_FAST_PS);

  logic [AGE_W-1:0] rrd_lim, faw_lim, rc_lim;
  logic [AGE_W-1:0] rrd_age;
  logic [AGE_W-1:0] faw_age [WIN];
  logic [AGE_W-1:0] bk_age  [NUM_BANKS];
  logic [1:0]       prev_gr;
  logic             viol_q, fresh, early;

  function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
    return (a == AGE_MAX) ? a : a + AGE_W'(1);
  endfunction

  always_comb begin
    unique case (gr_i)
      2'd0:    begin rrd_lim = AGE_W'(RRD_S); faw_lim = AGE_W'(FAW_S); rc_lim = AGE_W'(RC_S); end
      2'd1:    begin rrd_lim = AGE_W'(RRD_M); faw_lim = AGE_W'(FAW_M); rc_lim = AGE_W'(RC_M); end
      default: begin rrd_lim = AGE_W'(RRD_F); faw_lim = AGE_W'(FAW_F); rc_lim = AGE_W'(RC_F); end
    endcase
    fresh = (gr_i != prev_gr);
    early = (rrd_age < rrd_lim) || (faw_age[WIN-1] < faw_lim) || (bk_age[bank_i] < rc_lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_age <= AGE_MAX;
      for (int i = 0; i < WIN; i++) faw_age[i] <= AGE_MAX;
      for (int b = 0; b < NUM_BANKS; b++) bk_age[b] <= AGE_MAX;
      prev_gr <= '0;
      viol_q  <= 1'b0;
    end else if (cmd_i == CMD_ACT) begin
      if (!fresh && early) viol_q <= 1'b1;
      prev_gr    <= gr_i;
      rrd_age    <= AGE_W'(1);
      faw_age[0] <= AGE_W'(1);
      for (int i = 1; i < WIN; i++)
        faw_age[i] <= fresh ? AGE_MAX : sat_inc(faw_age[i-1]);
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (BANK_W'(b) == bank_i) bk_age[b] <= AGE_W'(1);
        else                      bk_age[b] <= fresh ? AGE_MAX : sat_inc(bk_age[b]);
      end
    end else begin
      rrd_age <= sat_inc(rrd_age);
      for (int i = 0; i < WIN; i++) faw_age[i] <= sat_inc(faw_age[i]);
      for (int b = 0; b < NUM_BANKS; b++) bk_age[b] <= sat_inc(bk_age[b]);
    end
  end

  assign viol_o = viol_q;

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(viol_q) |-> viol_q); // R10

  AST_PATTERN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_q); // R10

  AST_ACT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT) |=> (cmd_i != CMD_ACT)); // R6

endmodule

// File: rtl/dram_ilv_gen.sv
module dram_ilv_gen
  import ilv_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14,
  parameter int GROUP  = 4,
  parameter int AGE_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        grade_i,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cmd_vld_o,
  output logic              viol_o
);

  localparam int PH_W = 3;

  cmd_e              iss_cmd, cmd_q;
  logic [BANK_W-1:0] iss_bank;
  logic [1:0]        gr;

  ilv_seq #(.BANK_W(BANK_W), .GROUP(GROUP), .PH_W(PH_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .grade_i    (grade_i),
    .iss_cmd_o  (iss_cmd),
    .iss_bank_o (iss_bank),
    .gr_o       (gr)
  );

  ilv_cmd_reg #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iss_cmd_i  (iss_cmd),
    .iss_bank_i (iss_bank),
    .cmd_o      (cmd_q),
    .bank_o     (bank_o),
    .addr_o     (addr_o),
    .vld_o      (cmd_vld_o)
  );

  ilv_timing_chk #(.BANK_W(BANK_W), .AGE_W(AGE_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_q),
    .bank_i (bank_o),
    .gr_i   (gr),
    .viol_o (viol_o)
  );

  assign cmd_o = cmd_q;

endmodule

// File: tb/tb_dram_ilv_gen.sv
module tb_dram_ilv_gen;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 3;
  localparam int ADDR_W = 14;
  localparam int NCYC   = 3000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic [1:0]        grade_i = 2'd0;
  logic [1:0]        cmd_o;
  logic [BANK_W-1:0] bank_o;
  logic [ADDR_W-1:0] addr_o;
  logic              cmd_vld_o, viol_o;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  bit m_run = 0;
  int m_gr = 0, m_slot = 0;
  int e_cmd = 0, e_bank = 0, e_addr = 0;

  dram_ilv_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .grade_i(grade_i),
    .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o),
    .cmd_vld_o(cmd_vld_o), .viol_o(viol_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string rid, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", rid, act, exp, $time);
    end
  endtask

  function automatic int m_pb(input int g); return (g == 0) ? 0 : 1; endfunction
  function automatic int m_pe(input int g); return (g == 1) ? 1 : 2; endfunction
  function automatic int m_len(input int g); return 16 + 8*m_pb(g) + 2*m_pe(g); endfunction

  // slot -> command (0 des, 1 act, 2 rda) and bank
  task automatic decode(input int g, input int slot, output int cmd, output int bank);
    int s = slot;
    cmd = 0; bank = 0;
    for (int b = 0; b < 8; b++) begin
      int len = 2 + m_pb(g) + ((b % 4 == 3) ? m_pe(g) : 0);
      if (s < len) begin
        cmd  = (s == 0) ? 1 : (s == 1) ? 2 : 0;
        bank = b;
        return;
      end
      s -= len;
    end
  endtask

  task automatic model_step();
    int c, b;
    if (!m_run || m_slot == m_len(m_gr) - 1) begin
      if (en_i) begin m_run = 1; m_gr = int'(grade_i); m_slot = 0; end
      else m_run = 0;
    end else m_slot++;
    if (m_run) begin
      decode(m_gr, m_slot, c, b);
      e_cmd = c;
      if (c == 1) begin e_bank = b; e_addr = b; end
      else if (c == 2) begin e_bank = b; e_addr = 0; end
    end else e_cmd = 0;
  endtask

  task automatic compare();
    string rc;
    if (!m_run) rc = "R9";
    else if (m_gr == 0) rc = "R3";
    else if (m_gr == 1) rc = "R4";
    else rc = "R5";
    chk(rc, int'(cmd_o), e_cmd);
    chk("R2", int'(cmd_vld_o), (e_cmd != 0) ? 1 : 0);
    if (e_cmd == 0) begin
      chk("R8", int'(bank_o), e_bank);
      chk("R8", int'(addr_o), e_addr);
    end else begin
      chk("R6", int'(bank_o), e_bank);
      chk("R7", int'(addr_o), e_addr);
    end
    chk("R10", int'(viol_o), 0);
  endtask

  task automatic drive(input int c);
    if (c < 60)       begin en_i = 1; grade_i = 2'd0; end
    else if (c < 130) begin en_i = 1; grade_i = 2'd1; end
    else if (c < 200) begin en_i = 1; grade_i = 2'd2; end
    else if (c < 240) begin en_i = 0; grade_i = 2'd1; end
    else if (c < 300) begin en_i = 1; grade_i = 2'd3; end
    else begin
      en_i = (($urandom % 12) != 0);
      if (($urandom % 5) == 0) grade_i = 2'($urandom % 4);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0d2a));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", int'(cmd_o), 0);
    chk("R1", int'(cmd_vld_o), 0);
    chk("R1", int'(bank_o), 0);
    chk("R1", int'(addr_o), 0);
    chk("R1", int'(viol_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", int'(cmd_o), 0);
    // R9: idle with en low
    repeat (4) begin
      @(posedge clk_i); model_step();
      @(negedge clk_i); compare();
    end
    for (int c = 0; c < NCYC; c++) begin
      drive(c);
      @(posedge clk_i); model_step();
      @(negedge clk_i); compare();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule